// File: doc/BRIEF.md
# Clock Lane High-Speed Entry and Exit Sequencer

This block is the transmit-side sequencer for the clock lane of a serial camera or display link. It moves the lane from the low-power stop state into continuous high-speed clocking, then brings it back. It drives a two-bit low-power line state, a high-speed driver enable and a gate for the serialiser's bit clock. A data-lane controller asks for clocking by raising a request. The sequencer answers with a permit once the clock has run long enough for data lanes to start their own entry. When the controller's data lanes are back in low power, it drops the request.

Every interval is a count of timing-clock cycles taken from a configuration input. Each count is clamped to bounds derived from nanosecond limits and the timing-clock period, and a clamp raises a sticky error flag. On entry the lane drives LP-11 (stop), then LP-01, then LP-00 (prepare), then HS-0 (zero), then clocking. On exit it runs the clock for the post interval, drives HS-0 for the trail interval, then drives LP-11 for the exit interval. A new request that arrives during the exit is held until the exit completes.

Top module: `clk_lane_hs_seq`

## Requirements
- R1: After reset, lp_line is 2'b11, and hs_drive, hs_clk_en, data_hs_permit and cfg_err are all 0.
- R2: When hs_req is high in the stop state, lp_line is 2'b01 for the clamped cfg_lpx cycles, starting the cycle after the request is seen. lp_line is then 2'b00 with hs_drive low for the clamped cfg_prepare cycles.
- R3: The prepare count is clamped into the range [PREP_MIN, PREP_MAX]. These are the 38 ns and 95 ns limits converted to cycles, giving 4 to 9 cycles at defaults.
- R4: After prepare, the lane drives HS-0 (lp_line 2'b00, hs_drive 1, hs_clk_en 0) for the clamped cfg_zero cycles.
- R5: The clock then runs (hs_clk_en 1) for the clamped cfg_pre cycles with data_hs_permit low. After that, data_hs_permit is 1 for as long as hs_req stays high.
- R6: When hs_req is low in the permit state, data_hs_permit drops on the next cycle. The clock runs for the clamped cfg_post cycles, then HS-0 lasts for the clamped cfg_trail cycles. Then lp_line 2'b11 with hs_drive 0 lasts for the clamped cfg_exit cycles, followed by the stop state.
- R7: Counts below their minimum are raised to it. At defaults the minimums are 5 (lpx), 1 (zero), 2 (pre), 6 (post), 6 (trail) and 10 (exit) cycles.
- R8: cfg_err becomes 1 on the clock edge after any configuration count is out of its bounds. It stays 1 until reset.
- R9: A request raised during the post, trail or exit interval does not shorten them. The lane spends at least one stop cycle after the exit interval, so LP-11 lasts exit+1 cycles, before lp_line goes to 2'b01.
- R10: If hs_req is low when the pre interval ends, the lane goes straight to the post interval and data_hs_permit never asserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_req | input | 1 | Request for high-speed clocking from the data-lane controller |
| cfg_lpx | input | CNT_W | LP-01 dwell count |
| cfg_prepare | input | CNT_W | LP-00 prepare count |
| cfg_zero | input | CNT_W | HS-0 count before clocking |
| cfg_pre | input | CNT_W | Clock cycles before the data permit |
| cfg_post | input | CNT_W | Clock cycles after the request drops |
| cfg_trail | input | CNT_W | HS-0 count after the last clock bit |
| cfg_exit | input | CNT_W | LP-11 count after a burst |
| lp_line | output | 2 | Low-power line state {P,N} |
| hs_drive | output | 1 | High-speed driver enable |
| hs_clk_en | output | 1 | Bit-clock gate for the serialiser |
| data_hs_permit | output | 1 | Data lanes may be in high-speed mode |
| cfg_err | output | 1 | Sticky flag: a count was clamped |

## Verification
The bench targets a request withdrawn before the permit. A design that gets this wrong flashes the permit for one cycle while the clock stops. It targets a request re-raised during the post interval. A design that gets this wrong cuts the exit short or jumps from LP-11 into LP-00 with no stop cycle. It also drives out-of-range counts, both too small and a prepare count too large. A wrong design here runs the intervals at the raw value, or lets the error flag fall back when the configuration is repaired. The off-by-one risk in every interval is covered by a cycle-exact comparison against a reference model built from queued expected line states.

// File: rtl/clk_lane_seq_pkg.sv
package clk_lane_seq_pkg;

   typedef enum logic [3:0] {
      PH_STOP,
      PH_REQ,
      PH_PREP,
      PH_ZERO,
      PH_PRE,
      PH_RUN,
      PH_POST,
      PH_TRAIL,
      PH_EXIT
   } lane_phase_e;

   // interval slots in the clamp array; the FSM picks them by index
   localparam int IV_LPX   = 0;
   localparam int IV_PREP  = 1;
   localparam int IV_ZERO  = 2;
   localparam int IV_PRE   = 3;
   localparam int IV_POST  = 4;
   localparam int IV_TRAIL = 5;
   localparam int IV_EXIT  = 6;
   localparam int NUM_IV   = 7;

   function automatic int unsigned ps_to_cyc_up(int unsigned ps, int unsigned per);
      return (ps + per - 1) / per;
   endfunction

   function automatic int unsigned ps_to_cyc_down(int unsigned ps, int unsigned per);
      return ps / per;
   endfunction

endpackage

// File: rtl/clk_lane_clamp.sv
module clk_lane_clamp #(
   parameter int unsigned W  = 8,
   parameter int unsigned LO = 1,
   parameter int unsigned HI = 255
) (
   input  logic [W-1:0] raw,
   output logic [W-1:0] val,
   output logic         out_of_range
);
   localparam logic [W-1:0] LO_V = W'(LO);
   localparam logic [W-1:0] HI_V = W'(HI);

   if (LO == 0 || LO > HI) begin : g_bad_bounds
      $error("clk_lane_clamp: bounds must satisfy 1 <= LO <= HI");
   end

   always_comb begin
      val          = raw;
      out_of_range = 1'b0;
      if (raw < LO_V) begin
         val          = LO_V;
         out_of_range = 1'b1;
      end else if (raw > HI_V) begin
         val          = HI_V;
         out_of_range = 1'b1;
      end
   end
endmodule

// File: rtl/clk_lane_timer.sv
module clk_lane_timer #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         done
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val - 1'b1;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);

   AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (load_val != '0)); // R7
endmodule

// File: rtl/clk_lane_fsm.sv
module clk_lane_fsm
   import clk_lane_seq_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hs_req,
   input  logic [W-1:0] iv_len [NUM_IV],
   input  logic         tmr_done,
   output lane_phase_e  phase,
   output logic         tmr_load,
   output logic [W-1:0] tmr_val
);
   lane_phase_e nxt;

   always_comb begin
      nxt      = phase;
      tmr_load = 1'b0;
      tmr_val  = iv_len[IV_LPX];
      unique case (phase)
         PH_STOP: if (hs_req) begin
            nxt = PH_REQ;   tmr_load = 1'b1; tmr_val = iv_len[IV_LPX];
         end
         PH_REQ: if (tmr_done) begin
            nxt = PH_PREP;  tmr_load = 1'b1; tmr_val = iv_len[IV_PREP];
         end
         PH_PREP: if (tmr_done) begin
            nxt = PH_ZERO;  tmr_load = 1'b1; tmr_val = iv_len[IV_ZERO];
         end
         PH_ZERO: if (tmr_done) begin
            nxt = PH_PRE;   tmr_load = 1'b1; tmr_val = iv_len[IV_PRE];
         end
         PH_PRE: if (tmr_done) begin
            if (hs_req) nxt = PH_RUN;
            else begin
               nxt = PH_POST; tmr_load = 1'b1; tmr_val = iv_len[IV_POST];
            end
         end
         PH_RUN: if (!hs_req) begin
            nxt = PH_POST;  tmr_load = 1'b1; tmr_val = iv_len[IV_POST];
         end
         PH_POST: if (tmr_done) begin
            nxt = PH_TRAIL; tmr_load = 1'b1; tmr_val = iv_len[IV_TRAIL];
         end
         PH_TRAIL: if (tmr_done) begin
            nxt = PH_EXIT;  tmr_load = 1'b1; tmr_val = iv_len[IV_EXIT];
         end
         PH_EXIT: if (tmr_done) nxt = PH_STOP;
         default: nxt = PH_STOP;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase <= PH_STOP;
      else        phase <= nxt;
   end

   AST_REQ_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_REQ && $past(phase) != PH_REQ) |-> ($past(phase) == PH_STOP)); // R9
   AST_PREP_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_PREP && $past(phase) != PH_PREP) |-> ($past(phase) == PH_REQ)); // R2
   AST_ZERO_FROM_PREP: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ZERO && $past(phase) != PH_ZERO) |-> ($past(phase) == PH_PREP)); // R4
   AST_RUN_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_RUN) |-> $past(hs_req)); // R5
   AST_TRAIL_FROM_POST: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_TRAIL && $past(phase) != PH_TRAIL) |-> ($past(phase) == PH_POST)); // R6
endmodule

// File: rtl/clk_lane_outdec.sv
module clk_lane_outdec
   import clk_lane_seq_pkg::*;
#(
   parameter bit REG_OUT = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  lane_phase_e phase,
   output logic [1:0]  lp_line,
   output logic        hs_drive,
   output logic        clk_en,
   output logic        permit
);
   logic [1:0] d_lp;
   logic       d_hs, d_clk, d_permit;

   always_comb begin
      d_lp     = 2'b00;
      d_hs     = 1'b0;
      d_clk    = 1'b0;
      d_permit = 1'b0;
      unique case (phase)
         PH_STOP, PH_EXIT: d_lp = 2'b11;
         PH_REQ:           d_lp = 2'b01;
         PH_PREP:          d_lp = 2'b00;
         PH_ZERO, PH_TRAIL: d_hs = 1'b1;
         PH_PRE, PH_POST: begin d_hs = 1'b1; d_clk = 1'b1; end
         PH_RUN: begin d_hs = 1'b1; d_clk = 1'b1; d_permit = 1'b1; end
         default: d_lp = 2'b11;
      endcase
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lp_line  <= 2'b11;
            hs_drive <= 1'b0;
            clk_en   <= 1'b0;
            permit   <= 1'b0;
         end else begin
            lp_line  <= d_lp;
            hs_drive <= d_hs;
            clk_en   <= d_clk;
            permit   <= d_permit;
         end
      end
   end else begin : g_comb
      assign lp_line  = d_lp;
      assign hs_drive = d_hs;
      assign clk_en   = d_clk;
      assign permit   = d_permit;
   end

   AST_PERMIT_WITH_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      permit |-> (clk_en && hs_drive)); // R5
   AST_CLK_STOP_HS0: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_en) |-> hs_drive); // R6
endmodule

// File: rtl/clk_lane_hs_seq.sv
module clk_lane_hs_seq
   import clk_lane_seq_pkg::*;
#(
   parameter int unsigned CNT_W        = 8,
   parameter int unsigned TCLK_PS      = 10000,
   parameter int unsigned LPX_MIN_PS   = 50000,
   parameter int unsigned PREP_MIN_PS  = 38000,
   parameter int unsigned PREP_MAX_PS  = 95000,
   parameter int unsigned TRAIL_MIN_PS = 60000,
   parameter int unsigned EXIT_MIN_PS  = 100000,
   parameter int unsigned ZERO_MIN_CYC = 1,
   parameter int unsigned PRE_MIN_CYC  = 2,
   parameter int unsigned POST_MIN_CYC = 6,
   parameter bit          REG_OUT      = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hs_req,
   input  logic [CNT_W-1:0] cfg_lpx,
   input  logic [CNT_W-1:0] cfg_prepare,
   input  logic [CNT_W-1:0] cfg_zero,
   input  logic [CNT_W-1:0] cfg_pre,
   input  logic [CNT_W-1:0] cfg_post,
   input  logic [CNT_W-1:0] cfg_trail,
   input  logic [CNT_W-1:0] cfg_exit,
   output logic [1:0]       lp_line,
   output logic             hs_drive,
   output logic             hs_clk_en,
   output logic             data_hs_permit,
   output logic             cfg_err
);
   localparam int unsigned CNT_MAX   = (1 << CNT_W) - 1;
   localparam int unsigned LPX_MIN   = ps_to_cyc_up(LPX_MIN_PS, TCLK_PS);
   localparam int unsigned PREP_MIN  = ps_to_cyc_up(PREP_MIN_PS, TCLK_PS);
   localparam int unsigned PREP_MAX  = ps_to_cyc_down(PREP_MAX_PS, TCLK_PS);
   localparam int unsigned TRAIL_MIN = ps_to_cyc_up(TRAIL_MIN_PS, TCLK_PS);
   localparam int unsigned EXIT_MIN  = ps_to_cyc_up(EXIT_MIN_PS, TCLK_PS);

   localparam int unsigned IV_LO [NUM_IV] = '{LPX_MIN, PREP_MIN, ZERO_MIN_CYC,
      PRE_MIN_CYC, POST_MIN_CYC, TRAIL_MIN, EXIT_MIN};
   localparam int unsigned IV_HI [NUM_IV] = '{CNT_MAX, PREP_MAX, CNT_MAX,
      CNT_MAX, CNT_MAX, CNT_MAX, CNT_MAX};

   if (CNT_W < 2 || CNT_W > 24) begin : g_bad_width
      $error("clk_lane_hs_seq: CNT_W out of range");
   end
   if (TCLK_PS == 0) begin : g_bad_period
      $error("clk_lane_hs_seq: TCLK_PS must be nonzero");
   end
   if (PREP_MIN > PREP_MAX) begin : g_bad_prep
      $error("clk_lane_hs_seq: timing clock too slow for the prepare window");
   end
   if (EXIT_MIN > CNT_MAX || LPX_MIN > CNT_MAX || TRAIL_MIN > CNT_MAX) begin : g_bad_range
      $error("clk_lane_hs_seq: a minimum does not fit in CNT_W bits");
   end

   logic [CNT_W-1:0] raw_iv [NUM_IV];
   logic [CNT_W-1:0] iv_len [NUM_IV];
   logic [NUM_IV-1:0] oor;

   assign raw_iv[IV_LPX]   = cfg_lpx;
   assign raw_iv[IV_PREP]  = cfg_prepare;
   assign raw_iv[IV_ZERO]  = cfg_zero;
   assign raw_iv[IV_PRE]   = cfg_pre;
   assign raw_iv[IV_POST]  = cfg_post;
   assign raw_iv[IV_TRAIL] = cfg_trail;
   assign raw_iv[IV_EXIT]  = cfg_exit;

   for (genvar i = 0; i < NUM_IV; i++) begin : g_iv
      clk_lane_clamp #(
         .W  (CNT_W),
         .LO (IV_LO[i]),
         .HI (IV_HI[i])
      ) u_clamp (
         .raw          (raw_iv[i]),
         .val          (iv_len[i]),
         .out_of_range (oor[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_err <= 1'b0;
      else        cfg_err <= cfg_err | (|oor);
   end

   lane_phase_e      phase;
   logic             tmr_load, tmr_done;
   logic [CNT_W-1:0] tmr_val;

   clk_lane_fsm #(.W(CNT_W)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .hs_req   (hs_req),
      .iv_len   (iv_len),
      .tmr_done (tmr_done),
      .phase    (phase),
      .tmr_load (tmr_load),
      .tmr_val  (tmr_val)
   );

   clk_lane_timer #(.W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .done     (tmr_done)
   );

   clk_lane_outdec #(.REG_OUT(REG_OUT)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .phase    (phase),
      .lp_line  (lp_line),
      .hs_drive (hs_drive),
      .clk_en   (hs_clk_en),
      .permit   (data_hs_permit)
   );

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> cfg_err); // R8
   AST_HS_ONLY_LP00: assert property (@(posedge clk) disable iff (!rst_n)
      hs_drive |-> (lp_line == 2'b00)); // R4
endmodule

// File: tb/test_clk_lane_hs_seq.sv
module test_clk_lane_hs_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hs_req = 1'b0;
   logic [7:0] c_lpx = 8'd6, c_prep = 8'd5, c_zero = 8'd3, c_pre = 8'd4;
   logic [7:0] c_post = 8'd7, c_trail = 8'd6, c_exit = 8'd10;
   logic [1:0] lp_line;
   logic       hs_drive, hs_clk_en, data_hs_permit, cfg_err;

   always #5 clk = ~clk;

   clk_lane_hs_seq i_clk_lane_hs_seq (
      .clk(clk), .rst_n(rst_n), .hs_req(hs_req),
      .cfg_lpx(c_lpx), .cfg_prepare(c_prep), .cfg_zero(c_zero), .cfg_pre(c_pre),
      .cfg_post(c_post), .cfg_trail(c_trail), .cfg_exit(c_exit),
      .lp_line(lp_line), .hs_drive(hs_drive), .hs_clk_en(hs_clk_en),
      .data_hs_permit(data_hs_permit), .cfg_err(cfg_err));

   int n_checks = 0;
   int n_fails  = 0;

   // expected output codes {lp[1:0], hs, clk, permit}
   localparam logic [4:0] C_STOP = 5'b11000;
   localparam logic [4:0] C_REQ  = 5'b01000;
   localparam logic [4:0] C_PREP = 5'b00000;
   localparam logic [4:0] C_HS0  = 5'b00100;
   localparam logic [4:0] C_CLK  = 5'b00110;
   localparam logic [4:0] C_RUN  = 5'b00111;

   function automatic int clampv(int v, int lo, int hi);
      if (v < lo) return lo;
      if (v > hi) return hi;
      return v;
   endfunction

   // reference model
   logic [4:0] q_code[$];
   string      q_tag[$];
   int         mode = 0;          // 0 idle, 1 entry, 2 run, 3 exit
   logic [4:0] exp_code = C_STOP;
   string      exp_tag = "R1";
   logic       exp_err = 1'b0;
   logic       live = 1'b0;

   function automatic void push_n(logic [4:0] code, int n, string tag);
      for (int k = 0; k < n; k++) begin
         q_code.push_back(code);
         q_tag.push_back(tag);
      end
   endfunction

   function automatic bit any_clamp();
      return (c_lpx < 5) || (c_prep < 4) || (c_prep > 9) || (c_zero < 1) ||
             (c_pre < 2) || (c_post < 6) || (c_trail < 6) || (c_exit < 10);
   endfunction

   task automatic push_exit();
      push_n(C_CLK,  clampv(c_post, 6, 255),  "R6");
      push_n(C_HS0,  clampv(c_trail, 6, 255), "R6");
      push_n(C_STOP, clampv(c_exit, 10, 255), "R6");
      push_n(C_STOP, 1, "R9");
   endtask

   task automatic pop_exp();
      exp_code = q_code.pop_front();
      exp_tag  = q_tag.pop_front();
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         q_code.delete(); q_tag.delete();
         mode = 0; exp_code = C_STOP; exp_tag = "R1"; exp_err = 1'b0; live = 1'b0;
      end else begin
         live = 1'b1;
         if (any_clamp()) exp_err = 1'b1;
         case (mode)
            0: if (hs_req) begin
                  push_n(C_REQ,  clampv(c_lpx, 5, 255),  "R2");
                  push_n(C_PREP, clampv(c_prep, 4, 9),   "R3");
                  push_n(C_HS0,  clampv(c_zero, 1, 255), "R4");
                  push_n(C_CLK,  clampv(c_pre, 2, 255),  "R5");
                  mode = 1; pop_exp();
               end else begin
                  exp_code = C_STOP; exp_tag = "R9";
               end
            1: if (q_code.size() != 0) pop_exp();
               else if (hs_req) begin mode = 2; exp_code = C_RUN; exp_tag = "R5"; end
               else begin push_exit(); mode = 3; pop_exp(); exp_tag = "R10"; end
            2: if (hs_req) begin exp_code = C_RUN; exp_tag = "R5"; end
               else begin push_exit(); mode = 3; pop_exp(); end
            default: begin
               pop_exp();
               if (q_code.size() == 0) mode = 0;
            end
         endcase
      end
   end

   // per-cycle comparison
   always @(negedge clk) begin
      if (rst_n && live) begin
         n_checks++;
         if ({lp_line, hs_drive, hs_clk_en, data_hs_permit} != exp_code) begin
            n_fails++;
            $display("FAIL %s: outputs %b expected %b at %0t", exp_tag,
                     {lp_line, hs_drive, hs_clk_en, data_hs_permit}, exp_code, $time);
         end
         n_checks++;
         if (cfg_err != exp_err) begin
            n_fails++;
            $display("FAIL R8: cfg_err %b expected %b at %0t", cfg_err, exp_err, $time);
         end
      end
   end

   // run-length monitors
   logic [1:0] prev_lp = 2'b11;
   int run_lp = 0, len01 = 0, len11 = 0, run_prep = 0, len_prep = 0;
   bit permit_seen = 0;
   always @(negedge clk) begin
      if (lp_line == prev_lp) run_lp++;
      else begin
         if (prev_lp == 2'b01) len01 = run_lp;
         if (prev_lp == 2'b11 && lp_line == 2'b01) len11 = run_lp;
         run_lp = 1;
      end
      prev_lp = lp_line;
      if (lp_line == 2'b00 && !hs_drive) run_prep++;
      else begin
         if (run_prep != 0) len_prep = run_prep;
         run_prep = 0;
      end
      if (data_hs_permit) permit_seen = 1;
   end

   task automatic step(int n = 1);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic check(bit ok, string tag, int act, int expv);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: got %0d expected %0d", tag, act, expv);
      end
   endtask

   task automatic wait_permit();
      for (int k = 0; k < 300 && !data_hs_permit; k++) step();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog: run did not complete, got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

   initial begin
      step(3);
      // R1: reset state
      check(lp_line == 2'b11, "R1", lp_line, 3);
      check({hs_drive, hs_clk_en, data_hs_permit, cfg_err} == 4'b0, "R1",
            {hs_drive, hs_clk_en, data_hs_permit, cfg_err}, 0);
      rst_n = 1'b1;
      step(3);

      // scenario A: legal burst
      hs_req = 1'b1;
      wait_permit();
      check(data_hs_permit == 1'b1, "R5", data_hs_permit, 1);
      step(10);
      hs_req = 1'b0;
      step(40);
      check(len01 == 6, "R2", len01, 6);
      check(len_prep == 5, "R3", len_prep, 5);
      check(cfg_err == 1'b0, "R8", cfg_err, 0);

      // scenario B: re-request during post interval
      hs_req = 1'b1;
      wait_permit();
      step(5);
      hs_req = 1'b0;
      step(2);
      hs_req = 1'b1;
      wait_permit();
      check(len11 == 11, "R9", len11, 11);
      step(3);
      hs_req = 1'b0;
      step(40);

      // scenario C: request withdrawn before permit
      permit_seen = 0;
      hs_req = 1'b1;
      step(3);
      hs_req = 1'b0;
      step(60);
      check(permit_seen == 0, "R10", permit_seen, 0);

      // scenario D: clamping of short counts
      c_lpx = 8'd1; c_prep = 8'd2; c_zero = 8'd0; c_pre = 8'd0;
      c_post = 8'd1; c_trail = 8'd0; c_exit = 8'd3;
      step(2);
      check(cfg_err == 1'b1, "R8", cfg_err, 1);
      hs_req = 1'b1;
      wait_permit();
      step(4);
      hs_req = 1'b0;
      step(40);
      check(len01 == 5, "R7", len01, 5);
      check(len_prep == 4, "R3", len_prep, 4);

      // long prepare clamped to the maximum
      c_prep = 8'd20; c_lpx = 8'd5;
      hs_req = 1'b1;
      wait_permit();
      step(2);
      hs_req = 1'b0;
      step(40);
      check(len_prep == 9, "R3", len_prep, 9);

      // repaired configuration keeps the flag
      c_lpx = 8'd6; c_prep = 8'd5; c_zero = 8'd3; c_pre = 8'd4;
      c_post = 8'd7; c_trail = 8'd6; c_exit = 8'd10;
      step(5);
      check(cfg_err == 1'b1, "R8", cfg_err, 1);

      // reset clears everything
      rst_n = 1'b0;
      step(2);
      check(cfg_err == 1'b0, "R8", cfg_err, 0);
      check(lp_line == 2'b11, "R1", lp_line, 3);
      rst_n = 1'b1;
      step(5);

      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end
endmodule